// File: doc/BRIEF.md
# Split Tightly Coupled Memory Controller

This block sits between a processor core and two banks of synchronous on-chip RAM. It gives each bank its own short, fixed-latency path. The fetch side is read-only from the core. Each access returns one 64-bit word that carries two 32-bit instructions. Its RAM can be written only through a separate preload port, which is used while the memory is being initialised. The data side serves loads and stores over separate 32-bit read and write buses, with per-byte write enables. The second port of the data RAM belongs to fabric logic. The controller forwards that port and resolves write collisions on it.

Each side compares the upper bits of the request address with a base address supplied on an input, and ignores requests that fall outside its window or are not aligned to its word size. Read data appears one cycle after the request, with a valid strobe. Every returned word is also flagged as cache-inhibited, because nothing fetched over these paths may be cached. The default windows are 128 KB on the fetch side and 64 KB on the data side. Both sizes are parameters.

Top module: `tcm_split_ctrl`

## Requirements
- R1: A fetch request whose address is inside the fetch window and 8-byte aligned reads RAM word (addr - base)/8. The 64-bit word appears on `fetch_data` with `fetch_valid` high in the cycle after the request, and only then.
- R2: A fetch whose address bits above FETCH_WIN_LOG2 differ from those of `fetch_base`, or whose bits [2:0] are not zero, leaves `iram_en` low in that cycle and produces no `fetch_valid`.
- R3: The fetch RAM is written only when `preload_we` is high. The preload port then owns the RAM port, and a fetch issued in the same cycle is dropped: no valid is returned, and the RAM content at the fetch address is unchanged.
- R4: A load (`dreq` high, `dwe` low) inside the data window and 4-byte aligned returns word (addr - base)/4 on `drdata` with `dvalid` high one cycle later.
- R5: A data request outside the data window, or with bits [1:0] not zero, leaves `dram_en` low in that cycle, produces no `dvalid`, and writes nothing.
- R6: A store writes only the bytes whose `dbe` bit is set, with `dbe[k]` guarding `dwdata[8k+7:8k]`. A store never raises `dvalid`.
- R7: The fabric port signals reach the data RAM's second port unchanged in the same cycle, whenever no collision occurs.
- R8: When a processor store and a fabric write target the same data word in the same cycle, every byte enabled by the processor takes the processor data. The fabric still writes its other enabled bytes.
- R9: `fetch_cinh` and `dcinh` are high in exactly the cycles in which the matching valid is high. While a valid is low, its data bus reads zero.
- R10: While reset is asserted, and directly after it, both valids, both cache-inhibit flags and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_base | input | 32 | Base address of the fetch window |
| data_base | input | 32 | Base address of the data window |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_data | output | 64 | Fetched word, two instructions |
| fetch_valid | output | 1 | Fetch data valid |
| fetch_cinh | output | 1 | Fetched word is cache-inhibited |
| preload_we | input | 1 | Preload write strobe for the fetch RAM |
| preload_addr | input | FETCH_WIN_LOG2-3 | Preload word index |
| preload_wdata | input | 64 | Preload data |
| iram_en | output | 1 | Fetch RAM enable |
| iram_we | output | 1 | Fetch RAM write enable |
| iram_addr | output | FETCH_WIN_LOG2-3 | Fetch RAM word index |
| iram_wdata | output | 64 | Fetch RAM write data |
| iram_rdata | input | 64 | Fetch RAM read data, one cycle after enable |
| dreq | input | 1 | Data request strobe |
| dwe | input | 1 | 1 = store, 0 = load |
| dbe | input | 4 | Store byte enables |
| daddr | input | 32 | Data byte address |
| dwdata | input | 32 | Store data bus |
| drdata | output | 32 | Load data bus |
| dvalid | output | 1 | Load data valid |
| dcinh | output | 1 | Load data is cache-inhibited |
| dram_en | output | 1 | Data RAM port A enable |
| dram_we | output | 4 | Data RAM port A byte write enables |
| dram_addr | output | DATA_WIN_LOG2-2 | Data RAM port A word index |
| dram_wdata | output | 32 | Data RAM port A write data |
| dram_rdata | input | 32 | Data RAM port A read data |
| fab_en | input | 1 | Fabric port enable |
| fab_we | input | 4 | Fabric byte write enables |
| fab_addr | input | DATA_WIN_LOG2-2 | Fabric word index |
| fab_wdata | input | 32 | Fabric write data |
| dramb_en | output | 1 | Data RAM port B enable |
| dramb_we | output | 4 | Data RAM port B byte write enables |
| dramb_addr | output | DATA_WIN_LOG2-2 | Data RAM port B word index |
| dramb_wdata | output | 32 | Data RAM port B write data |

## Verification
A broken window decode shows in the request cycle itself: the RAM enable rises for a miss, or stays low for a hit. A miss store that aliases into the window also corrupts a word, which a later load in range exposes. A valid register that is wrong shows one cycle after the request, as a valid that is missing or spurious, or as data that is not zero while valid is low. A faulty byte merge or collision mask stays hidden until the word is loaded again, so each store and each collision is followed by a load of the same word.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned FETCH_W = 64;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;

  // Upper bits of address and base agree above the window size.
  function automatic logic win_match(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input int unsigned lg);
    return (a >> lg) == (b >> lg);
  endfunction

  // Byte lanes the fabric may still write when the core stores too.
  function automatic logic [LANES-1:0] fab_lanes(input logic [LANES-1:0] core_we,
                                                 input logic [LANES-1:0] fab_we,
                                                 input logic             same_word);
    return same_word ? (fab_we & ~core_we) : fab_we;
  endfunction
endpackage

// File: rtl/tcm_fetch_side.sv
module tcm_fetch_side #(
  parameter int unsigned WIN_LOG2 = 17,
  localparam int unsigned AW = WIN_LOG2 - 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [31:0]                  base,
  input  logic                         req,
  input  logic [31:0]                  addr,
  input  logic                         pl_we,
  input  logic [AW-1:0]                pl_addr,
  input  logic [tcm_pkg::FETCH_W-1:0]  pl_wdata,
  output logic                         ram_en,
  output logic                         ram_we,
  output logic [AW-1:0]                ram_addr,
  output logic [tcm_pkg::FETCH_W-1:0]  ram_wdata,
  input  logic [tcm_pkg::FETCH_W-1:0]  ram_rdata,
  output logic [tcm_pkg::FETCH_W-1:0]  rdata,
  output logic                         valid,
  output logic                         cinh
);
  logic fetch_hit;
  logic fetch_issue;
  logic fetch_dropped;
  logic valid_q;

  assign fetch_hit     = req && tcm_pkg::win_match(addr, base, WIN_LOG2) && (addr[2:0] == 3'b000);
  assign fetch_issue   = fetch_hit && !pl_we;
  assign fetch_dropped = fetch_hit && pl_we;

  assign ram_en    = fetch_issue || pl_we;
  assign ram_we    = pl_we;
  assign ram_addr  = pl_we ? pl_addr : addr[WIN_LOG2-1:3];
  assign ram_wdata = pl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fetch_issue;
  end

  assign valid = valid_q;
  assign cinh  = valid_q;
  assign rdata = valid_q ? ram_rdata : '0;

  AST_FETCH_NO_CORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> pl_we);                                              // R3
  AST_FETCH_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(req && !pl_we));                                // R1
  AST_FETCH_DROP_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_dropped |=> !valid);                                      // R3
  AST_FETCH_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !pl_we) |-> !ram_en);                                  // R2
  AST_FETCH_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (rdata == '0 && !cinh));                             // R9
endmodule

// File: rtl/tcm_data_side.sv
module tcm_data_side #(
  parameter int unsigned WIN_LOG2 = 16,
  localparam int unsigned AW = WIN_LOG2 - 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [31:0]                 base,
  input  logic                        req,
  input  logic                        we,
  input  logic [tcm_pkg::LANES-1:0]   be,
  input  logic [31:0]                 addr,
  input  logic [tcm_pkg::DATA_W-1:0]  wdata,
  output logic                        ram_en,
  output logic [tcm_pkg::LANES-1:0]   ram_we,
  output logic [AW-1:0]               ram_addr,
  output logic [tcm_pkg::DATA_W-1:0]  ram_wdata,
  input  logic [tcm_pkg::DATA_W-1:0]  ram_rdata,
  output logic [tcm_pkg::DATA_W-1:0]  rdata,
  output logic                        valid,
  output logic                        cinh
);
  logic data_hit;
  logic load_issue;
  logic store_issue;
  logic valid_q;

  assign data_hit    = req && tcm_pkg::win_match(addr, base, WIN_LOG2) && (addr[1:0] == 2'b00);
  assign load_issue  = data_hit && !we;
  assign store_issue = data_hit && we;

  assign ram_en    = data_hit;
  assign ram_we    = store_issue ? be : '0;
  assign ram_addr  = addr[WIN_LOG2-1:2];
  assign ram_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load_issue;
  end

  assign valid = valid_q;
  assign cinh  = valid_q;
  assign rdata = valid_q ? ram_rdata : '0;

  AST_DATA_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(req && !we));                                   // R4
  AST_DATA_STORE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !valid);                                        // R6
  AST_DATA_WE_WITHIN_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we & ~be) == '0);                                          // R6
  AST_DATA_EN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> req);                                                // R5
  AST_DATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (rdata == '0 && !cinh));                             // R9
endmodule

// File: rtl/tcm_port_b_guard.sv
module tcm_port_b_guard #(
  parameter int unsigned AW = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [tcm_pkg::LANES-1:0]   core_we,
  input  logic [AW-1:0]               core_addr,
  input  logic                        f_en,
  input  logic [tcm_pkg::LANES-1:0]   f_we,
  input  logic [AW-1:0]               f_addr,
  input  logic [tcm_pkg::DATA_W-1:0]  f_wdata,
  output logic                        b_en,
  output logic [tcm_pkg::LANES-1:0]   b_we,
  output logic [AW-1:0]               b_addr,
  output logic [tcm_pkg::DATA_W-1:0]  b_wdata
);
  logic same_word;

  assign same_word = (core_we != '0) && f_en && (core_addr == f_addr);

  assign b_en    = f_en;
  assign b_we    = f_en ? tcm_pkg::fab_lanes(core_we, f_we, same_word) : '0;
  assign b_addr  = f_addr;
  assign b_wdata = f_wdata;

  AST_NO_LANE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (b_addr == core_addr) |-> ((b_we & core_we) == '0));            // R8
  AST_FAB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_en && core_we == '0) |-> (b_we == f_we));                    // R7
endmodule

// File: rtl/tcm_split_ctrl.sv
module tcm_split_ctrl #(
  parameter int unsigned FETCH_WIN_LOG2 = 17,
  parameter int unsigned DATA_WIN_LOG2  = 16,
  localparam int unsigned FAW = FETCH_WIN_LOG2 - 3,
  localparam int unsigned DAW = DATA_WIN_LOG2 - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     fetch_base,
  input  logic [31:0]     data_base,
  input  logic            fetch_req,
  input  logic [31:0]     fetch_addr,
  output logic [63:0]     fetch_data,
  output logic            fetch_valid,
  output logic            fetch_cinh,
  input  logic            preload_we,
  input  logic [FAW-1:0]  preload_addr,
  input  logic [63:0]     preload_wdata,
  output logic            iram_en,
  output logic            iram_we,
  output logic [FAW-1:0]  iram_addr,
  output logic [63:0]     iram_wdata,
  input  logic [63:0]     iram_rdata,
  input  logic            dreq,
  input  logic            dwe,
  input  logic [3:0]      dbe,
  input  logic [31:0]     daddr,
  input  logic [31:0]     dwdata,
  output logic [31:0]     drdata,
  output logic            dvalid,
  output logic            dcinh,
  output logic            dram_en,
  output logic [3:0]      dram_we,
  output logic [DAW-1:0]  dram_addr,
  output logic [31:0]     dram_wdata,
  input  logic [31:0]     dram_rdata,
  input  logic            fab_en,
  input  logic [3:0]      fab_we,
  input  logic [DAW-1:0]  fab_addr,
  input  logic [31:0]     fab_wdata,
  output logic            dramb_en,
  output logic [3:0]      dramb_we,
  output logic [DAW-1:0]  dramb_addr,
  output logic [31:0]     dramb_wdata
);
  tcm_fetch_side #(.WIN_LOG2(FETCH_WIN_LOG2)) u_fetch (
    .clk(clk), .rst_n(rst_n), .base(fetch_base),
    .req(fetch_req), .addr(fetch_addr),
    .pl_we(preload_we), .pl_addr(preload_addr), .pl_wdata(preload_wdata),
    .ram_en(iram_en), .ram_we(iram_we), .ram_addr(iram_addr),
    .ram_wdata(iram_wdata), .ram_rdata(iram_rdata),
    .rdata(fetch_data), .valid(fetch_valid), .cinh(fetch_cinh)
  );

  tcm_data_side #(.WIN_LOG2(DATA_WIN_LOG2)) u_data (
    .clk(clk), .rst_n(rst_n), .base(data_base),
    .req(dreq), .we(dwe), .be(dbe), .addr(daddr), .wdata(dwdata),
    .ram_en(dram_en), .ram_we(dram_we), .ram_addr(dram_addr),
    .ram_wdata(dram_wdata), .ram_rdata(dram_rdata),
    .rdata(drdata), .valid(dvalid), .cinh(dcinh)
  );

  tcm_port_b_guard #(.AW(DAW)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .core_we(dram_we), .core_addr(dram_addr),
    .f_en(fab_en), .f_we(fab_we), .f_addr(fab_addr), .f_wdata(fab_wdata),
    .b_en(dramb_en), .b_we(dramb_we), .b_addr(dramb_addr), .b_wdata(dramb_wdata)
  );
endmodule

// File: tb/tcm_split_ctrl_bench.sv
module tcm_split_ctrl_bench;
  localparam int FL = 10;
  localparam int DL = 10;
  localparam int FAW = FL - 3;
  localparam int DAW = DL - 2;
  localparam int FWORDS = 1 << FAW;
  localparam int DWORDS = 1 << DAW;
  localparam logic [31:0] FBASE = 32'hFFFF_8000;
  localparam logic [31:0] DBASE = 32'h0000_4000;

  typedef struct packed {
    logic [1:0]  op;    // 0 fetch, 1 load, 2 store
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        hit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'hFFFF_8000, 4'h0, 32'h0, 1'b1},
    '{2'd0, 32'hFFFF_83F8, 4'h0, 32'h0, 1'b1},
    '{2'd0, 32'hFFFF_8400, 4'h0, 32'h0, 1'b0},
    '{2'd0, 32'hFFFF_8004, 4'h0, 32'h0, 1'b0},
    '{2'd1, 32'h0000_4000, 4'h0, 32'h0, 1'b1},
    '{2'd1, 32'h0000_43FC, 4'h0, 32'h0, 1'b1},
    '{2'd2, 32'h0000_4010, 4'hF, 32'hDEAD_BEEF, 1'b1},
    '{2'd1, 32'h0000_4010, 4'h0, 32'h0, 1'b1},
    '{2'd2, 32'h0000_4010, 4'h5, 32'h1122_3344, 1'b1},
    '{2'd1, 32'h0000_4010, 4'h0, 32'h0, 1'b1},
    '{2'd2, 32'h0000_4400, 4'hF, 32'hBAD0_BAD0, 1'b0},
    '{2'd1, 32'h0000_3FFC, 4'h0, 32'h0, 1'b0},
    '{2'd1, 32'h0000_4002, 4'h0, 32'h0, 1'b0},
    '{2'd0, 32'hFFFF_8208, 4'h0, 32'h0, 1'b1},
    '{2'd1, 32'h0000_4000, 4'h0, 32'h0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            fetch_req = 0;
  logic [31:0]     fetch_addr = 0;
  logic [63:0]     fetch_data;
  logic            fetch_valid, fetch_cinh;
  logic            preload_we = 0;
  logic [FAW-1:0]  preload_addr = 0;
  logic [63:0]     preload_wdata = 0;
  logic            iram_en, iram_we;
  logic [FAW-1:0]  iram_addr;
  logic [63:0]     iram_wdata, iram_rdata;
  logic            dreq = 0, dwe = 0;
  logic [3:0]      dbe = 0;
  logic [31:0]     daddr = 0, dwdata = 0;
  logic [31:0]     drdata;
  logic            dvalid, dcinh;
  logic            dram_en;
  logic [3:0]      dram_we;
  logic [DAW-1:0]  dram_addr;
  logic [31:0]     dram_wdata, dram_rdata;
  logic            fab_en = 0;
  logic [3:0]      fab_we = 0;
  logic [DAW-1:0]  fab_addr = 0;
  logic [31:0]     fab_wdata = 0;
  logic            dramb_en;
  logic [3:0]      dramb_we;
  logic [DAW-1:0]  dramb_addr;
  logic [31:0]     dramb_wdata;

  tcm_split_ctrl #(.FETCH_WIN_LOG2(FL), .DATA_WIN_LOG2(DL)) u_tcm_split_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_base(FBASE), .data_base(DBASE),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .fetch_valid(fetch_valid), .fetch_cinh(fetch_cinh),
    .preload_we(preload_we), .preload_addr(preload_addr), .preload_wdata(preload_wdata),
    .iram_en(iram_en), .iram_we(iram_we), .iram_addr(iram_addr),
    .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
    .dreq(dreq), .dwe(dwe), .dbe(dbe), .daddr(daddr), .dwdata(dwdata),
    .drdata(drdata), .dvalid(dvalid), .dcinh(dcinh),
    .dram_en(dram_en), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .fab_en(fab_en), .fab_we(fab_we), .fab_addr(fab_addr), .fab_wdata(fab_wdata),
    .dramb_en(dramb_en), .dramb_we(dramb_we), .dramb_addr(dramb_addr),
    .dramb_wdata(dramb_wdata)
  );

  // Behavioural synchronous RAMs.
  logic [63:0] imem [FWORDS];
  logic [31:0] dmem [DWORDS];
  always_ff @(posedge clk) begin
    if (iram_en) begin
      if (iram_we) imem[iram_addr] <= iram_wdata;
      else         iram_rdata <= imem[iram_addr];
    end
    if (dram_en && dram_we == 4'h0) dram_rdata <= dmem[dram_addr];
    for (int b = 0; b < 4; b++) begin
      if (dram_en && dram_we[b])   dmem[dram_addr][8*b +: 8]  <= dram_wdata[8*b +: 8];
      if (dramb_en && dramb_we[b]) dmem[dramb_addr][8*b +: 8] <= dramb_wdata[8*b +: 8];
    end
  end

  // Bench-side expectations.
  logic [63:0] ish [FWORDS];
  logic [31:0] dsh [DWORDS];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [63:0] ipat(input int i);
    return {32'h4000_0000 + i, 32'h7000_0000 + 3 * i};
  endfunction
  function automatic logic [31:0] dpat(input int i);
    return 32'hC0DE_0000 ^ (i * 32'h0101);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    fetch_req = 0; preload_we = 0; dreq = 0; dwe = 0; dbe = 0; fab_en = 0; fab_we = 0;
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 fetch_valid in reset", {63'b0, fetch_valid}, 64'd0);
    check("R10 dvalid in reset", {63'b0, dvalid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 outputs after reset", {fetch_data[31:0], drdata}, 64'd0);
    check("R10 cinh after reset", {62'b0, fetch_cinh, dcinh}, 64'd0);

    // Preload fetch RAM through the preload port (R3).
    for (int i = 0; i < FWORDS; i++) begin
      preload_we = 1; preload_addr = FAW'(i); preload_wdata = ipat(i); ish[i] = ipat(i);
      @(negedge clk);
    end
    preload_we = 0;

    // Preload data RAM through the fabric port (R7).
    for (int i = 0; i < DWORDS; i++) begin
      fab_en = 1; fab_we = 4'hF; fab_addr = DAW'(i); fab_wdata = dpat(i); dsh[i] = dpat(i);
      if (i == 7) begin
        #1;
        check("R7 port B pass-through",
              {27'b0, dramb_en, dramb_we, dramb_addr, dramb_wdata},
              {27'b0, 1'b1, 4'hF, DAW'(7), dpat(7)});
      end
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);

    // Vector table.
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      if (t.op == 2'd0) begin
        fetch_req = 1; fetch_addr = t.addr;
        #1 check($sformatf("R2 iram_en vec %0d", v), {63'b0, iram_en}, {63'b0, t.hit});
        @(negedge clk);
        check($sformatf("R1 fetch_valid vec %0d", v), {63'b0, fetch_valid}, {63'b0, t.hit});
        check($sformatf("R1 fetch_data vec %0d", v), fetch_data,
              t.hit ? ish[(t.addr - FBASE) >> 3] : 64'd0);
        check($sformatf("R9 fetch_cinh vec %0d", v), {63'b0, fetch_cinh}, {63'b0, t.hit});
      end else begin
        dreq = 1; dwe = (t.op == 2'd2); dbe = t.be; daddr = t.addr; dwdata = t.wd;
        #1 check($sformatf("R5 dram_en vec %0d", v), {63'b0, dram_en}, {63'b0, t.hit});
        if (t.op == 2'd2 && t.hit) begin
          for (int b = 0; b < 4; b++)
            if (t.be[b]) dsh[(t.addr - DBASE) >> 2][8*b +: 8] = t.wd[8*b +: 8];
        end
        @(negedge clk);
        if (t.op == 2'd2) begin
          check($sformatf("R6 no dvalid on store vec %0d", v), {63'b0, dvalid}, 64'd0);
        end else begin
          check($sformatf("R4 dvalid vec %0d", v), {63'b0, dvalid}, {63'b0, t.hit});
          check($sformatf("R4 drdata vec %0d", v), {32'b0, drdata},
                {32'b0, t.hit ? dsh[(t.addr - DBASE) >> 2] : 32'd0});
          check($sformatf("R9 dcinh vec %0d", v), {63'b0, dcinh}, {63'b0, t.hit});
        end
      end
      idle_inputs();
    end

    // R3: preload and fetch in the same cycle; fetch dropped.
    preload_we = 1; preload_addr = FAW'(5); preload_wdata = 64'h5555_AAAA_0F0F_F0F0;
    ish[5] = 64'h5555_AAAA_0F0F_F0F0;
    fetch_req = 1; fetch_addr = FBASE + 32'd72;
    @(negedge clk);
    check("R3 concurrent fetch dropped", {63'b0, fetch_valid}, 64'd0);
    idle_inputs();
    fetch_req = 1; fetch_addr = FBASE + 32'd40;
    @(negedge clk);
    check("R3 preloaded word read back", fetch_data, ish[5]);
    fetch_addr = FBASE + 32'd72;
    @(negedge clk);
    check("R3 dropped fetch address unchanged", fetch_data, ish[9]);
    idle_inputs();

    // R8: core store and fabric write to the same word.
    dreq = 1; dwe = 1; dbe = 4'h3; daddr = DBASE + 32'h20; dwdata = 32'h1111_2222;
    fab_en = 1; fab_we = 4'hF; fab_addr = DAW'(8); fab_wdata = 32'h9999_8888;
    #1 check("R8 fabric lanes masked", {60'b0, dramb_we}, {60'b0, 4'hC});
    @(negedge clk);
    idle_inputs();
    dreq = 1; daddr = DBASE + 32'h20;
    @(negedge clk);
    check("R8 merged word", {32'b0, drdata}, {32'b0, 32'h9999_2222});
    idle_inputs();
    @(negedge clk);
    check("R9 idle data zero", {fetch_data[31:0], drdata}, 64'd0);

    finish_run();
  end
endmodule